// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block chooses the handshake reply for each token addressed to one USB endpoint with an IN and an OUT direction. It sees decoded token events, the end of the host's data packet (length, CRC result and the DATA0/DATA1 PID bit), the host's own handshake after an IN data packet, and the FIFO's byte count and free space. In most cases it replies without firmware help: a full packet in the FIFO is sent, and an OUT packet that fits is ACKed and committed. NAK is the reply whenever the transfer cannot proceed.

Firmware steers the reply with override bits. A per-direction force-STALL level wins over everything. A per-direction force-NAK bit, which can also be set by hardware after each committed OUT, comes next. A direction select says which way the current control stage runs. A one-shot short-packet enable lets an IN send fewer than the maximum packet size. Each direction keeps a data toggle bit, and seven sticky status flags feed a maskable interrupt.

The controller is one state machine with four states. ST_IDLE waits for a token. On an IN token it sends data and moves to ST_IN_WAIT, or it replies at once and stays. An OUT token moves it to ST_OUT_DATA, and a SETUP token moves it to ST_SETUP_DATA. ST_IN_WAIT returns to ST_IDLE on the host's ACK or on a timeout. ST_OUT_DATA and ST_SETUP_DATA return to ST_IDLE when the data packet ends.

Top module: `usb_ep_responder`

## Requirements
- R1: With the direction select at IN, an IN token seen while `fifo_level` >= MAX_PKT raises `in_send` in the same cycle, with `in_len` = MAX_PKT. With fewer bytes available and the short-packet enable off, the reply is NAK (`hs_code` 2) and nothing is sent.
- R2: An OUT data packet with a good CRC whose length fits in `fifo_space` gets ACK (`hs_code` 1). If the length exceeds the free space, the reply is NAK and `out_commit` stays low.
- R3: While `fnak_in`/`fnak_out` is set, every token of that direction is answered NAK whatever the FIFO state. The bits are set and cleared by one-cycle strobes, and set wins when both strobes come in the same cycle.
- R4: A force-STALL level answers that direction with STALL (`hs_code` 3), with priority over force-NAK and over the FIFO decision.
- R5: When `auto_nak_en` is high, every committed OUT packet sets `fnak_out`, so the next OUT is NAKed.
- R6: With `short_en` set, an IN sends `fifo_level` bytes (zero included) when fewer than MAX_PKT are present. `short_en` clears itself when the host ACKs a packet shorter than MAX_PKT, and it stays set after a full-size packet.
- R7: `tog_in` flips only on a host ACK of sent IN data, and `tog_out` flips only on a committed OUT packet. NAK, STALL, timeout and CRC error leave both unchanged. The set and clear strobes force a toggle to 1 or to 0. `in_data1` shows the PID bit to send.
- R8: A SETUP token followed by a good-CRC data packet is always ACKed and committed. It sets both toggles to 1 and sets flag bit 6.
- R9: An OUT packet whose PID bit differs from `tog_out` is ACKed, but it is not committed and the toggle does not flip.
- R10: `dir_in`=1 makes the control stage run IN, and an OUT then gets NAK. `dir_in`=0 makes it run OUT, and an IN then gets NAK.
- R11: An OUT packet with a bad CRC gets no handshake (`hs_valid` low) and sets flag bit 5. A `host_timeout` in ST_IN_WAIT sets flag bit 4.
- R12: Flags are sticky: bit0 IN ACK, bit1 OUT ACK, bit2 IN NAK, bit3 OUT NAK, bit4 IN error, bit5 OUT error, bit6 SETUP. Writing 1 to a bit of `flag_clr` clears it. `irq` is high while any set flag has its `irq_en` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token type: 0 OUT, 1 IN, 2 SETUP |
| pkt_done | input | 1 | End of the host data packet |
| pkt_len | input | LEN_W | Received packet length in bytes |
| pkt_crc_ok | input | 1 | CRC of the received packet is good |
| pkt_data1 | input | 1 | Received PID was DATA1 |
| host_ack | input | 1 | Host ACKed the IN data |
| host_timeout | input | 1 | No host handshake after IN data |
| fifo_level | input | LVL_W | Bytes ready for IN |
| fifo_space | input | LVL_W | Free bytes for OUT |
| dir_in | input | 1 | Control stage direction, 1 = IN |
| force_stall_in | input | 1 | STALL every IN |
| force_stall_out | input | 1 | STALL every OUT |
| fnak_set_in | input | 1 | Set the IN force-NAK bit |
| fnak_clr_in | input | 1 | Clear the IN force-NAK bit |
| fnak_set_out | input | 1 | Set the OUT force-NAK bit |
| fnak_clr_out | input | 1 | Clear the OUT force-NAK bit |
| auto_nak_en | input | 1 | Set OUT force-NAK after each commit |
| short_set | input | 1 | Arm the short-packet enable |
| tog_set_in | input | 1 | Force the IN toggle to 1 |
| tog_clr_in | input | 1 | Force the IN toggle to 0 |
| tog_set_out | input | 1 | Force the OUT toggle to 1 |
| tog_clr_out | input | 1 | Force the OUT toggle to 0 |
| flag_clr | input | 7 | Write-1-to-clear mask for the flags |
| irq_en | input | 7 | Interrupt enable per flag |
| hs_valid | output | 1 | Handshake is to be sent this cycle |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| in_send | output | 1 | Send an IN data packet this cycle |
| in_len | output | LEN_W | Length of that packet |
| in_data1 | output | 1 | PID bit for the IN packet |
| out_commit | output | 1 | Keep the received packet in the FIFO |
| tog_in | output | 1 | IN data toggle |
| tog_out | output | 1 | OUT data toggle |
| fnak_in | output | 1 | IN force-NAK bit |
| fnak_out | output | 1 | OUT force-NAK bit |
| short_en | output | 1 | Short-packet enable |
| flags | output | 7 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that STALL wins over every other IN reply and that nothing is sent while force-NAK is set. They also check that a sent length never exceeds MAX_PKT or the FIFO level, that a short packet is sent only with the enable set, that an OUT commit always fits the free space, and that a timeout leaves the toggle alone. They further check that a SETUP forces both toggles high and that flags stay set until cleared. The bench scenarios show the end-to-end sequences that no single cycle shows: the enable clearing only after a short packet, auto-NAK blocking the following OUT, a PID mismatch being ACKed without a commit, and a wrong-direction token being NAKed.

// File: rtl/usb_hs_pkg.sv
`timescale 1ns/1ps
package usb_hs_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    localparam logic [1:0] TK_OUT   = 2'd0;
    localparam logic [1:0] TK_IN    = 2'd1;
    localparam logic [1:0] TK_SETUP = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OUT_DATA,
        ST_SETUP_DATA,
        ST_IN_WAIT
    } st_e;

    localparam int NFLAG     = 7;
    localparam int F_IN_ACK  = 0;
    localparam int F_OUT_ACK = 1;
    localparam int F_IN_NAK  = 2;
    localparam int F_OUT_NAK = 3;
    localparam int F_IN_ERR  = 4;
    localparam int F_OUT_ERR = 5;
    localparam int F_SETUP   = 6;
endpackage

// File: rtl/usb_in_arbiter.sv
`timescale 1ns/1ps
module usb_in_arbiter
    import usb_hs_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int LVL_W   = 8,
    parameter int LEN_W   = 7
) (
    input  logic             stall,
    input  logic             fnak,
    input  logic             dir_ok,
    input  logic             short_en,
    input  logic [LVL_W-1:0] level,
    output logic             send,
    output logic [LEN_W-1:0] len,
    output hs_e              hs
);
    logic full;

    always_comb begin
        full = 32'(level) >= 32'(MAX_PKT);
        send = !stall && !fnak && dir_ok && (full || short_en);
        len  = full ? LEN_W'(MAX_PKT) : LEN_W'(level);
        if (stall)     hs = HS_STALL;
        else if (send) hs = HS_NONE;
        else           hs = HS_NAK;
    end
endmodule

// File: rtl/usb_out_arbiter.sv
`timescale 1ns/1ps
module usb_out_arbiter
    import usb_hs_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int LEN_W = 7
) (
    input  logic             stall,
    input  logic             fnak,
    input  logic             dir_ok,
    input  logic             crc_ok,
    input  logic             pid1,
    input  logic             toggle,
    input  logic [LEN_W-1:0] len,
    input  logic [LVL_W-1:0] space,
    output hs_e              hs,
    output logic             commit,
    output logic             err
);
    always_comb begin
        hs     = HS_NONE;
        commit = 1'b0;
        err    = 1'b0;
        if (!crc_ok) begin
            err = 1'b1;
        end else if (stall) begin
            hs = HS_STALL;
        end else if (fnak || !dir_ok || (32'(len) > 32'(space))) begin
            hs = HS_NAK;
        end else begin
            hs     = HS_ACK;
            commit = (pid1 == toggle);
        end
    end
endmodule

// File: rtl/usb_ep_state.sv
`timescale 1ns/1ps
module usb_ep_state (
    input  logic clk,
    input  logic rst_n,
    input  logic fnak_set_in,
    input  logic fnak_clr_in,
    input  logic fnak_set_out,
    input  logic fnak_clr_out,
    input  logic auto_set_out,
    input  logic short_set,
    input  logic short_clr,
    input  logic tog_set_in,
    input  logic tog_clr_in,
    input  logic tog_set_out,
    input  logic tog_clr_out,
    input  logic in_flip,
    input  logic out_flip,
    input  logic setup_evt,
    output logic fnak_in,
    output logic fnak_out,
    output logic short_en,
    output logic tog_in,
    output logic tog_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fnak_in  <= 1'b0;
            fnak_out <= 1'b0;
            short_en <= 1'b0;
            tog_in   <= 1'b0;
            tog_out  <= 1'b0;
        end else begin
            if (fnak_set_in)                       fnak_in <= 1'b1;
            else if (fnak_clr_in)                  fnak_in <= 1'b0;
            if (fnak_set_out || auto_set_out)      fnak_out <= 1'b1;
            else if (fnak_clr_out)                 fnak_out <= 1'b0;
            if (short_set)                         short_en <= 1'b1;
            else if (short_clr)                    short_en <= 1'b0;
            if (tog_set_in)                        tog_in <= 1'b1;
            else if (tog_clr_in)                   tog_in <= 1'b0;
            else if (setup_evt)                    tog_in <= 1'b1;
            else if (in_flip)                      tog_in <= ~tog_in;
            if (tog_set_out)                       tog_out <= 1'b1;
            else if (tog_clr_out)                  tog_out <= 1'b0;
            else if (setup_evt)                    tog_out <= 1'b1;
            else if (out_flip)                     tog_out <= ~tog_out;
        end
    end

    AST_SETUP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_evt && !tog_clr_in && !tog_clr_out) |=> (tog_in && tog_out)); // R8

    AST_AUTO_NAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_set_out && !fnak_clr_out) |=> fnak_out); // R5
endmodule

// File: rtl/usb_status_flags.sv
`timescale 1ns/1ps
module usb_status_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    assign irq = |(flags & en);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0)); // R12
endmodule

// File: rtl/usb_ep_responder.sv
`timescale 1ns/1ps
module usb_ep_responder
    import usb_hs_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int LVL_W   = 8,
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             pkt_done,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             pkt_crc_ok,
    input  logic             pkt_data1,
    input  logic             host_ack,
    input  logic             host_timeout,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_space,
    input  logic             dir_in,
    input  logic             force_stall_in,
    input  logic             force_stall_out,
    input  logic             fnak_set_in,
    input  logic             fnak_clr_in,
    input  logic             fnak_set_out,
    input  logic             fnak_clr_out,
    input  logic             auto_nak_en,
    input  logic             short_set,
    input  logic             tog_set_in,
    input  logic             tog_clr_in,
    input  logic             tog_set_out,
    input  logic             tog_clr_out,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] irq_en,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             in_send,
    output logic [LEN_W-1:0] in_len,
    output logic             in_data1,
    output logic             out_commit,
    output logic             tog_in,
    output logic             tog_out,
    output logic             fnak_in,
    output logic             fnak_out,
    output logic             short_en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    st_e              st_q, st_d;
    logic             sent_short_q;
    logic             in_ok, out_cm, out_err;
    hs_e              in_hs, out_hs, hs;
    logic [NFLAG-1:0] flag_set;
    logic             in_flip, out_flip, short_clr, setup_evt, auto_set;

    usb_in_arbiter #(.MAX_PKT(MAX_PKT), .LVL_W(LVL_W), .LEN_W(LEN_W)) u_in (
        .stall(force_stall_in), .fnak(fnak_in), .dir_ok(dir_in),
        .short_en(short_en), .level(fifo_level),
        .send(in_ok), .len(in_len), .hs(in_hs)
    );

    usb_out_arbiter #(.LVL_W(LVL_W), .LEN_W(LEN_W)) u_out (
        .stall(force_stall_out), .fnak(fnak_out), .dir_ok(!dir_in),
        .crc_ok(pkt_crc_ok), .pid1(pkt_data1), .toggle(tog_out),
        .len(pkt_len), .space(fifo_space),
        .hs(out_hs), .commit(out_cm), .err(out_err)
    );

    usb_ep_state u_state (
        .clk(clk), .rst_n(rst_n),
        .fnak_set_in(fnak_set_in), .fnak_clr_in(fnak_clr_in),
        .fnak_set_out(fnak_set_out), .fnak_clr_out(fnak_clr_out),
        .auto_set_out(auto_set), .short_set(short_set), .short_clr(short_clr),
        .tog_set_in(tog_set_in), .tog_clr_in(tog_clr_in),
        .tog_set_out(tog_set_out), .tog_clr_out(tog_clr_out),
        .in_flip(in_flip), .out_flip(out_flip), .setup_evt(setup_evt),
        .fnak_in(fnak_in), .fnak_out(fnak_out), .short_en(short_en),
        .tog_in(tog_in), .tog_out(tog_out)
    );

    usb_status_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
        .en(irq_en), .flags(flags), .irq(irq)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            sent_short_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (in_send) sent_short_q <= 32'(in_len) < 32'(MAX_PKT);
        end
    end

    // Transitions and outputs
    always_comb begin
        st_d       = st_q;
        hs_valid   = 1'b0;
        hs         = HS_NONE;
        in_send    = 1'b0;
        out_commit = 1'b0;
        flag_set   = '0;
        in_flip    = 1'b0;
        out_flip   = 1'b0;
        short_clr  = 1'b0;
        setup_evt  = 1'b0;
        auto_set   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (tok_valid) begin
                    if (tok_kind == TK_IN) begin
                        if (in_ok) begin
                            in_send = 1'b1;
                            st_d    = ST_IN_WAIT;
                        end else begin
                            hs_valid = 1'b1;
                            hs       = in_hs;
                            flag_set[F_IN_NAK] = (in_hs == HS_NAK);
                        end
                    end else if (tok_kind == TK_OUT) begin
                        st_d = ST_OUT_DATA;
                    end else if (tok_kind == TK_SETUP) begin
                        st_d = ST_SETUP_DATA;
                    end
                end
            end
            ST_OUT_DATA: begin
                if (pkt_done) begin
                    st_d = ST_IDLE;
                    if (out_err) begin
                        flag_set[F_OUT_ERR] = 1'b1;
                    end else begin
                        hs_valid   = 1'b1;
                        hs         = out_hs;
                        flag_set[F_OUT_ACK] = (out_hs == HS_ACK);
                        flag_set[F_OUT_NAK] = (out_hs == HS_NAK);
                        out_commit = out_cm;
                        out_flip   = out_cm;
                        auto_set   = out_cm && auto_nak_en;
                    end
                end
            end
            ST_SETUP_DATA: begin
                if (pkt_done) begin
                    st_d = ST_IDLE;
                    if (pkt_crc_ok) begin
                        hs_valid   = 1'b1;
                        hs         = HS_ACK;
                        out_commit = 1'b1;
                        setup_evt  = 1'b1;
                        flag_set[F_SETUP] = 1'b1;
                    end
                end
            end
            ST_IN_WAIT: begin
                if (host_ack) begin
                    st_d      = ST_IDLE;
                    in_flip   = 1'b1;
                    short_clr = sent_short_q;
                    flag_set[F_IN_ACK] = 1'b1;
                end else if (host_timeout) begin
                    st_d = ST_IDLE;
                    flag_set[F_IN_ERR] = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign hs_code  = hs;
    assign in_data1 = tog_in;

    AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && tok_valid && tok_kind == TK_IN && force_stall_in)
        |-> (hs_valid && hs_code == HS_STALL && !in_send)); // R4

    AST_NO_SEND_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        in_send |-> (!fnak_in && !force_stall_in)); // R3

    AST_IN_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_send |-> (32'(in_len) <= 32'(MAX_PKT) && 32'(in_len) <= 32'(fifo_level))); // R1

    AST_SHORT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_send && 32'(in_len) < 32'(MAX_PKT)) |-> short_en); // R6

    AST_COMMIT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_commit && st_q == ST_OUT_DATA) |-> (32'(pkt_len) <= 32'(fifo_space))); // R2

    AST_TIMEOUT_HOLDS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IN_WAIT && host_timeout && !host_ack && !tog_set_in && !tog_clr_in)
        |=> (tog_in == $past(tog_in))); // R7
endmodule

// File: tb/tb_usb_ep_responder.sv
`timescale 1ns/1ps
module tb_usb_ep_responder;
    localparam int MAX_PKT = 64;
    localparam int LVL_W   = 8;
    localparam int LEN_W   = $clog2(MAX_PKT + 1);
    localparam int ACK = 1, NAK = 2, STALL = 3;
    localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_valid = 0, pkt_done = 0, pkt_crc_ok = 0, pkt_data1 = 0;
    logic [1:0] tok_kind = 0;
    logic [LEN_W-1:0] pkt_len = 0;
    logic host_ack = 0, host_timeout = 0, dir_in = 0;
    logic [LVL_W-1:0] fifo_level = 0, fifo_space = 0;
    logic force_stall_in = 0, force_stall_out = 0;
    logic fnak_set_in = 0, fnak_clr_in = 0, fnak_set_out = 0, fnak_clr_out = 0;
    logic auto_nak_en = 0, short_set = 0;
    logic tog_set_in = 0, tog_clr_in = 0, tog_set_out = 0, tog_clr_out = 0;
    logic [6:0] flag_clr = 0, irq_en = 0;
    logic hs_valid, in_send, in_data1, out_commit, tog_in, tog_out;
    logic fnak_in, fnak_out, short_en, irq;
    logic [1:0] hs_code;
    logic [LEN_W-1:0] in_len;
    logic [6:0] flags;

    int checks = 0, errors = 0;
    bit done = 0;

    usb_ep_responder #(.MAX_PKT(MAX_PKT), .LVL_W(LVL_W)) dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rel();
        @(negedge clk);
        tok_valid = 0; pkt_done = 0; host_ack = 0; host_timeout = 0;
        fnak_set_in = 0; fnak_clr_in = 0; fnak_set_out = 0; fnak_clr_out = 0;
        short_set = 0; tog_set_in = 0; tog_clr_in = 0; tog_set_out = 0;
        tog_clr_out = 0; flag_clr = 0;
        #1;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 7'h7F; rel();
    endtask

    task automatic in_tok(input int lvl);
        @(negedge clk); fifo_level = LVL_W'(lvl); tok_kind = K_IN; tok_valid = 1; #1;
    endtask

    task automatic ack_in();
        @(negedge clk); host_ack = 1; rel();
    endtask

    task automatic out_pkt(input logic [1:0] kind, input int len, input logic crc, input logic d1);
        @(negedge clk); tok_kind = kind; tok_valid = 1; rel();
        @(negedge clk); pkt_len = LEN_W'(len); pkt_crc_ok = crc; pkt_data1 = d1;
        pkt_done = 1; #1;
    endtask

    task automatic t_reset();
        chk("R12 reset flags", flags, 0);
        chk("R12 reset irq", irq, 0);
        chk("R7 reset tog_in", tog_in, 0);
        chk("R7 reset tog_out", tog_out, 0);
        chk("R3 reset fnak", {fnak_in, fnak_out, short_en}, 0);
        chk("R1 reset outputs", {hs_valid, in_send, out_commit}, 0);
    endtask

    task automatic t_in_full();
        dir_in = 1;
        in_tok(64);
        chk("R1 full send", in_send, 1);
        chk("R1 full len", in_len, 64);
        chk("R7 data pid", in_data1, 0);
        chk("R1 no handshake", hs_valid, 0);
        rel(); ack_in();
        chk("R7 IN flip on ack", tog_in, 1);
        chk("R12 IN ack flag", flags[0], 1);
    endtask

    task automatic t_in_low();
        clear_flags();
        in_tok(10);
        chk("R1 low level NAK", hs_code, NAK);
        chk("R1 low level valid", hs_valid, 1);
        chk("R1 low level no send", in_send, 0);
        rel();
        chk("R12 IN nak flag", flags[2], 1);
        chk("R7 no flip on NAK", tog_in, 1);
    endtask

    task automatic t_short();
        @(negedge clk); short_set = 1; rel();
        chk("R6 short armed", short_en, 1);
        in_tok(10);
        chk("R6 short send", in_send, 1);
        chk("R6 short len", in_len, 10);
        rel(); ack_in();
        chk("R6 self clear", short_en, 0);
        @(negedge clk); short_set = 1; rel();
        in_tok(70);
        chk("R6 full len with enable", in_len, 64);
        rel(); ack_in();
        chk("R6 kept after full", short_en, 1);
        in_tok(0);
        chk("R6 zero length send", in_send, 1);
        chk("R6 zero length len", in_len, 0);
        rel(); ack_in();
        chk("R6 clear after zero", short_en, 0);
    endtask

    task automatic t_fnak();
        @(negedge clk); fnak_set_in = 1; rel();
        chk("R3 fnak set", fnak_in, 1);
        in_tok(64);
        chk("R3 forced NAK", hs_code, NAK);
        chk("R3 forced no send", in_send, 0);
        rel();
        @(negedge clk); fnak_clr_in = 1; rel();
        chk("R3 fnak cleared", fnak_in, 0);
        in_tok(64);
        chk("R3 send after clear", in_send, 1);
        rel(); ack_in();
    endtask

    task automatic t_stall();
        @(negedge clk); fnak_set_in = 1; force_stall_in = 1; rel();
        in_tok(64);
        chk("R4 STALL over fnak", hs_code, STALL);
        chk("R4 STALL no send", in_send, 0);
        rel();
        force_stall_in = 0;
        @(negedge clk); fnak_clr_in = 1; rel();
        dir_in = 0; force_stall_out = 1; fifo_space = 100;
        out_pkt(K_OUT, 8, 1, tog_out);
        chk("R4 OUT STALL", hs_code, STALL);
        chk("R4 OUT STALL no commit", out_commit, 0);
        rel();
        force_stall_out = 0;
    endtask

    task automatic t_out();
        logic d;
        dir_in = 0; fifo_space = 100;
        clear_flags();
        d = tog_out;
        out_pkt(K_OUT, 8, 1, d);
        chk("R2 OUT ACK", hs_code, ACK);
        chk("R2 OUT commit", out_commit, 1);
        rel();
        chk("R7 OUT flip", tog_out, !d);
        chk("R12 OUT ack flag", flags[1], 1);
        d = tog_out; fifo_space = 4;
        out_pkt(K_OUT, 8, 1, d);
        chk("R2 no space NAK", hs_code, NAK);
        chk("R2 no space no commit", out_commit, 0);
        rel();
        chk("R12 OUT nak flag", flags[3], 1);
        chk("R7 no flip on OUT NAK", tog_out, d);
        fifo_space = 100;
        out_pkt(K_OUT, 8, 1, !d);
        chk("R9 mismatch ACK", hs_code, ACK);
        chk("R9 mismatch dropped", out_commit, 0);
        rel();
        chk("R9 mismatch no flip", tog_out, d);
    endtask

    task automatic t_autonak();
        auto_nak_en = 1;
        out_pkt(K_OUT, 4, 1, tog_out);
        chk("R5 commit before", out_commit, 1);
        rel();
        chk("R5 fnak_out set", fnak_out, 1);
        out_pkt(K_OUT, 4, 1, tog_out);
        chk("R5 next OUT NAK", hs_code, NAK);
        rel();
        auto_nak_en = 0;
        @(negedge clk); fnak_clr_out = 1; rel();
        chk("R3 fnak_out cleared", fnak_out, 0);
    endtask

    task automatic t_setup();
        @(negedge clk); tog_clr_in = 1; tog_clr_out = 1; rel();
        chk("R7 clear strobes", {tog_in, tog_out}, 0);
        @(negedge clk); tog_set_out = 1; rel();
        chk("R7 set strobe", tog_out, 1);
        @(negedge clk); tog_clr_out = 1; rel();
        clear_flags();
        out_pkt(K_SETUP, 8, 1, 0);
        chk("R8 SETUP ACK", hs_code, ACK);
        chk("R8 SETUP commit", out_commit, 1);
        rel();
        chk("R8 toggles set", {tog_in, tog_out}, 3);
        chk("R8 setup flag", flags[6], 1);
    endtask

    task automatic t_dir();
        dir_in = 0;
        in_tok(64);
        chk("R10 IN in OUT stage NAK", hs_code, NAK);
        chk("R10 IN in OUT stage no send", in_send, 0);
        rel();
        dir_in = 1;
        out_pkt(K_OUT, 4, 1, tog_out);
        chk("R10 OUT in IN stage NAK", hs_code, NAK);
        rel();
    endtask

    task automatic t_err();
        logic t;
        dir_in = 0;
        clear_flags();
        out_pkt(K_OUT, 4, 0, tog_out);
        chk("R11 bad CRC silent", hs_valid, 0);
        chk("R11 bad CRC no commit", out_commit, 0);
        rel();
        chk("R11 OUT err flag", flags[5], 1);
        dir_in = 1; t = tog_in;
        in_tok(64); rel();
        @(negedge clk); host_timeout = 1; rel();
        chk("R11 IN err flag", flags[4], 1);
        chk("R7 no flip on timeout", tog_in, t);
    endtask

    task automatic t_irq();
        @(negedge clk); irq_en = 7'h10; #1;
        chk("R12 irq enabled flag", irq, 1);
        @(negedge clk); flag_clr = 7'h10; rel();
        chk("R12 w1c one bit", flags, 7'h20);
        chk("R12 irq drops", irq, 0);
        irq_en = 7'h20; #1;
        chk("R12 irq other flag", irq, 1);
        irq_en = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_in_full();
        t_in_low();
        t_short();
        t_fnak();
        t_stall();
        t_out();
        t_autonak();
        t_setup();
        t_dir();
        t_err();
        t_irq();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule